// File: doc/BRIEF.md
# Block Cipher Chaining-Mode Engine

This block sits between a data stream and an external block cipher core and turns that core into one of four chaining modes: electronic codebook, counter, cipher feedback and cipher block chaining. Each mode runs in both directions. There is one data input and one data output. The input carries plaintext when encrypting and ciphertext when decrypting. The output carries the other of the two.

The engine holds one chaining-state register. Counter mode uses it as the counter, and the feedback modes use it as the previous-ciphertext register. The engine also holds the XOR logic and the steering multiplexers. It sends one block at a time to the cipher over a request/acknowledge handshake. There is a forward (encrypt) channel and an inverse (decrypt) channel. The inverse channel is used only where the mode cannot avoid it: codebook decryption and block-chaining decryption. The key and the cipher rounds stay outside the engine.

A user loads an initialization value with a strobe, picks a mode and a direction, and streams blocks through the valid/ready input. Results come back as single-cycle output pulses.

Top module: `cipher_mode_wrap`

## Requirements
- R1: Mode code 0 (codebook). The output is the forward cipher of the input when `decrypt_i`=0, and the inverse cipher of the input when `decrypt_i`=1.
- R2: Mode code 1 (counter). The output is the forward cipher of the state XOR the input, in both directions. The inverse channel is never requested in this mode.
- R3: In mode 1 the state increments by one after every block, modulo 2^W, so an all-ones state wraps to zero.
- R4: Mode code 2 (feedback). The output is the forward cipher of the state XOR the input, using the forward channel only. The state then becomes the ciphertext: the input when decrypting, the output when encrypting.
- R5: Mode code 3 (chaining) with `decrypt_i`=0. The output is the forward cipher of (state XOR input), and the state becomes that output.
- R6: Mode code 3 with `decrypt_i`=1. The output is the inverse cipher of the input XOR the state, and the state becomes the input.
- R7: While the block is idle, `iv_load_i` writes `iv_i` into the state register and holds `in_ready_o` low in that cycle.
- R8: Only one block is in flight. `in_ready_o` stays low from acceptance until the result is delivered. A cipher request stays high until its acknowledge.
- R9: `out_valid_o` rises in the cycle after the cipher acknowledge and lasts exactly one cycle.
- R10: The mode and direction are captured when a block is accepted. Changes to them while a block is in flight have no effect on that block.
- R11: Codebook blocks leave the state register unchanged, so a later chained block continues from the earlier chain.
- R12: After reset, `in_ready_o`=1, `out_valid_o`=0 and neither cipher request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 codebook, 1 counter, 2 feedback, 3 chaining |
| decrypt_i | input | 1 | 1 selects decryption |
| iv_load_i | input | 1 | Load strobe for the state register |
| iv_i | input | W | Initialization value |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Engine can accept a block |
| in_data_i | input | W | Plaintext or ciphertext in |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | W | Ciphertext or plaintext out |
| fwd_req_o | output | 1 | Forward cipher request |
| fwd_blk_o | output | W | Block sent to the forward cipher |
| fwd_ack_i | input | 1 | Forward cipher acknowledge, result valid |
| fwd_res_i | input | W | Forward cipher result |
| inv_req_o | output | 1 | Inverse cipher request |
| inv_blk_o | output | W | Block sent to the inverse cipher |
| inv_ack_i | input | 1 | Inverse cipher acknowledge, result valid |
| inv_res_i | input | W | Inverse cipher result |

## Verification
The bench builds the engine with W=16. At that width, counter wrap-around from 16'hFFFF is reached with a single initialization load, and a keyed 16-bit rotate-add permutation can be inverted in closed form by the bench. At this width, all eight mode/direction pairs are swept over long streams with cipher latencies from zero to three cycles. Every encrypted stream is also decrypted and checked to return the original plaintext.

// File: rtl/cmw_pkg.sv
package cmw_pkg;
    typedef enum logic [1:0] {
        MODE_ECB = 2'd0,
        MODE_CTR = 2'd1,
        MODE_CFB = 2'd2,
        MODE_CBC = 2'd3
    } cmw_mode_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } cmw_phase_e;
endpackage

// File: rtl/cmw_front.sv
// Pre-cipher steering: picks the cipher channel and the block to send.
module cmw_front
    import cmw_pkg::*;
#(
    parameter int W = 128
) (
    input  cmw_mode_e      mode,
    input  logic           dec,
    input  logic [W-1:0]   chain,
    input  logic [W-1:0]   blk,
    output logic           use_inv,
    output logic [W-1:0]   feed
);
    always_comb begin
        use_inv = 1'b0;
        feed    = blk;
        unique case (mode)
            MODE_ECB: begin
                use_inv = dec;
                feed    = blk;
            end
            MODE_CTR, MODE_CFB: begin
                use_inv = 1'b0;
                feed    = chain;
            end
            MODE_CBC: begin
                use_inv = dec;
                feed    = dec ? blk : (chain ^ blk);
            end
            default: begin
                use_inv = 1'b0;
                feed    = blk;
            end
        endcase
    end
endmodule

// File: rtl/cmw_back.sv
// Post-cipher steering: result word and next chaining state.
module cmw_back
    import cmw_pkg::*;
#(
    parameter int W = 128
) (
    input  cmw_mode_e      mode,
    input  logic           dec,
    input  logic [W-1:0]   chain,
    input  logic [W-1:0]   blk,
    input  logic [W-1:0]   res,
    output logic [W-1:0]   result,
    output logic [W-1:0]   chain_nx
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        result   = res;
        chain_nx = chain;
        unique case (mode)
            MODE_ECB: begin
                result   = res;
                chain_nx = chain;
            end
            MODE_CTR: begin
                result   = res ^ blk;
                chain_nx = chain + ONE;
            end
            MODE_CFB: begin
                result   = res ^ blk;
                chain_nx = dec ? blk : (res ^ blk);
            end
            MODE_CBC: begin
                result   = dec ? (res ^ chain) : res;
                chain_nx = dec ? blk : res;
            end
            default: begin
                result   = res;
                chain_nx = chain;
            end
        endcase
    end
endmodule

// File: rtl/cipher_mode_wrap.sv
module cipher_mode_wrap
    import cmw_pkg::*;
#(
    parameter int W = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode_i,
    input  logic           decrypt_i,
    input  logic           iv_load_i,
    input  logic [W-1:0]   iv_i,
    input  logic           in_valid_i,
    output logic           in_ready_o,
    input  logic [W-1:0]   in_data_i,
    output logic           out_valid_o,
    output logic [W-1:0]   out_data_o,
    output logic           fwd_req_o,
    output logic [W-1:0]   fwd_blk_o,
    input  logic           fwd_ack_i,
    input  logic [W-1:0]   fwd_res_i,
    output logic           inv_req_o,
    output logic [W-1:0]   inv_blk_o,
    input  logic           inv_ack_i,
    input  logic [W-1:0]   inv_res_i
);
    typedef struct packed {
        cmw_phase_e    ph;
        cmw_mode_e     mode;
        logic          dec;
        logic [W-1:0]  blk;
        logic [W-1:0]  chain;
        logic          ov;
        logic [W-1:0]  od;
    } regs_t;

    regs_t r_q, r_d;

    logic          use_inv;
    logic [W-1:0]  feed;
    logic          ack_sel;
    logic [W-1:0]  res_sel;
    logic [W-1:0]  result;
    logic [W-1:0]  chain_nx;
    logic          busy;

    cmw_front #(.W(W)) u_front (
        .mode    (r_q.mode),
        .dec     (r_q.dec),
        .chain   (r_q.chain),
        .blk     (r_q.blk),
        .use_inv (use_inv),
        .feed    (feed)
    );

    assign ack_sel = use_inv ? inv_ack_i : fwd_ack_i;
    assign res_sel = use_inv ? inv_res_i : fwd_res_i;

    cmw_back #(.W(W)) u_back (
        .mode     (r_q.mode),
        .dec      (r_q.dec),
        .chain    (r_q.chain),
        .blk      (r_q.blk),
        .res      (res_sel),
        .result   (result),
        .chain_nx (chain_nx)
    );

    assign busy        = (r_q.ph == PH_BUSY);
    assign in_ready_o  = !busy && !iv_load_i;
    assign fwd_req_o   = busy && !use_inv;
    assign inv_req_o   = busy && use_inv;
    assign fwd_blk_o   = feed;
    assign inv_blk_o   = feed;
    assign out_valid_o = r_q.ov;
    assign out_data_o  = r_q.od;

    always_comb begin
        r_d    = r_q;
        r_d.ov = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (iv_load_i) begin
                    r_d.chain = iv_i;
                end else if (in_valid_i) begin
                    r_d.ph   = PH_BUSY;
                    r_d.mode = cmw_mode_e'(mode_i);
                    r_d.dec  = decrypt_i;
                    r_d.blk  = in_data_i;
                end
            end
            PH_BUSY: begin
                if (ack_sel) begin
                    r_d.ph    = PH_IDLE;
                    r_d.ov    = 1'b1;
                    r_d.od    = result;
                    r_d.chain = chain_nx;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Assertions
    a_r12_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_req_o, inv_req_o}));

    a_r8_fwd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req_o && !fwd_ack_i) |=> fwd_req_o);

    a_r8_inv_held: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req_o && !inv_ack_i) |=> inv_req_o);

    a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req_o || inv_req_o) |-> !in_ready_o);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o);

    a_r9_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((fwd_req_o && fwd_ack_i) || (inv_req_o && inv_ack_i)) |=> out_valid_o);

    a_r2_fwd_only: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req_o |-> ((r_q.mode == MODE_ECB || r_q.mode == MODE_CBC) && r_q.dec));

    a_r3_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_sel && r_q.mode == MODE_CTR) |=> (r_q.chain == $past(r_q.chain) + W'(1)));

    a_r11_ecb_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.mode == MODE_ECB) |=> $stable(r_q.chain));

    a_r7_iv_load: assert property (@(posedge clk) disable iff (!rst_n)
        (iv_load_i && !busy) |=> (r_q.chain == $past(iv_i)));
endmodule

// File: tb/sim_cipher_mode_wrap.sv
`timescale 1ns/1ps
module sim_cipher_mode_wrap;
    localparam int W = 16;
    localparam logic [W-1:0] KX = 16'h3A5C;
    localparam logic [W-1:0] KA = 16'h1234;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic          decrypt_i = 1'b0;
    logic          iv_load_i = 1'b0;
    logic [W-1:0]  iv_i = '0;
    logic          in_valid_i = 1'b0;
    logic          in_ready_o;
    logic [W-1:0]  in_data_i = '0;
    logic          out_valid_o;
    logic [W-1:0]  out_data_o;
    logic          fwd_req_o;
    logic [W-1:0]  fwd_blk_o;
    logic          fwd_ack_i = 1'b0;
    logic [W-1:0]  fwd_res_i = '0;
    logic          inv_req_o;
    logic [W-1:0]  inv_blk_o;
    logic          inv_ack_i = 1'b0;
    logic [W-1:0]  inv_res_i = '0;

    cipher_mode_wrap #(.W(W)) u0 (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wcnt = 0;
    int cur_mode = 0;
    int inv_bad = 0;
    logic [W-1:0] m_st = '0;
    logic [W-1:0] ct_buf [0:39];
    logic [W-1:0] pt_buf [0:39];

    function automatic logic [W-1:0] enc(input logic [W-1:0] x);
        logic [W-1:0] t;
        t = x ^ KX;
        return {t[W-6:0], t[W-1:W-5]} + KA;
    endfunction

    function automatic logic [W-1:0] dcr(input logic [W-1:0] y);
        logic [W-1:0] t;
        t = y - KA;
        return {t[4:0], t[W-1:5]} ^ KX;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Toy cipher with programmable latency
    always @(negedge clk) begin
        if (fwd_ack_i || inv_ack_i) begin
            fwd_ack_i = 1'b0;
            inv_ack_i = 1'b0;
        end else if (fwd_req_o) begin
            if (wcnt >= lat) begin
                fwd_res_i = enc(fwd_blk_o);
                fwd_ack_i = 1'b1;
                wcnt = 0;
            end else wcnt++;
        end else if (inv_req_o) begin
            if (wcnt >= lat) begin
                inv_res_i = dcr(inv_blk_o);
                inv_ack_i = 1'b1;
                wcnt = 0;
            end else wcnt++;
        end
    end

    // R2 / R4: inverse channel must stay idle in counter and feedback modes
    always @(posedge clk) begin
        if (inv_req_o && (cur_mode == 1 || cur_mode == 2)) inv_bad++;
    end

    task automatic model(input int md, input bit dc, input logic [W-1:0] x,
                         output logic [W-1:0] y);
        case (md)
            0: y = dc ? dcr(x) : enc(x);
            1: begin y = enc(m_st) ^ x; m_st = m_st + 16'd1; end
            2: begin y = enc(m_st) ^ x; m_st = dc ? x : y; end
            default: begin
                if (!dc) begin y = enc(m_st ^ x); m_st = y; end
                else begin y = dcr(x) ^ m_st; m_st = x; end
            end
        endcase
    endtask

    task automatic load_iv(input logic [W-1:0] v);
        @(negedge clk);
        iv_load_i = 1'b1;
        iv_i = v;
        in_valid_i = 1'b1;
        #1;
        check("R7 ready low during load", {15'd0, in_ready_o}, 16'd0);
        @(negedge clk);
        iv_load_i = 1'b0;
        in_valid_i = 1'b0;
        m_st = v;
    endtask

    task automatic run_block(input int md, input bit dc, input logic [W-1:0] x,
                             input string req, output logic [W-1:0] got);
        logic [W-1:0] exp;
        int t;
        model(md, dc, x, exp);
        @(negedge clk);
        cur_mode = md;
        mode_i = md[1:0];
        decrypt_i = dc;
        in_data_i = x;
        in_valid_i = 1'b1;
        t = 0;
        while (!in_ready_o && t < 50) begin @(negedge clk); t++; end
        @(negedge clk);
        in_valid_i = 1'b0;
        // R10: disturb the selects while the block is in flight
        mode_i = md[1:0] + 2'd1;
        decrypt_i = !dc;
        in_data_i = ~x;
        if (!out_valid_o) check("R8 ready low while busy", {15'd0, in_ready_o}, 16'd0);
        t = 0;
        while (!out_valid_o && t < 50) begin @(negedge clk); t++; end
        got = out_data_o;
        check(req, got, exp);
        @(negedge clk);
        check("R9 single-cycle pulse", {15'd0, out_valid_o}, 16'd0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        repeat (3) @(negedge clk);
        check("R12 reset ready", {15'd0, in_ready_o}, 16'd1);
        check("R12 reset out_valid", {15'd0, out_valid_o}, 16'd0);
        check("R12 reset requests", {14'd0, fwd_req_o, inv_req_o}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 codebook round trip
        for (int i = 0; i < 8; i++) begin
            lat = i % 4;
            pt_buf[i] = 16'h0101 * i[15:0] + 16'h00F3;
            run_block(0, 1'b0, pt_buf[i], "R1 codebook encrypt", got);
            ct_buf[i] = got;
        end
        for (int i = 0; i < 8; i++) begin
            run_block(0, 1'b1, ct_buf[i], "R1 codebook decrypt", got);
            check("R1 codebook round trip", got, pt_buf[i]);
        end

        // Sweep chained modes (R2, R4, R5, R6): encrypt then decrypt
        for (int md = 1; md < 4; md++) begin
            load_iv(16'hC0DE + md[15:0]);
            for (int i = 0; i < 40; i++) begin
                lat = (i + md) % 4;
                pt_buf[i] = (16'h9E37 * i[15:0]) ^ md[15:0];
                if (md == 1) run_block(md, 1'b0, pt_buf[i], "R2 counter encrypt", got);
                else if (md == 2) run_block(md, 1'b0, pt_buf[i], "R4 feedback encrypt", got);
                else run_block(md, 1'b0, pt_buf[i], "R5 chaining encrypt", got);
                ct_buf[i] = got;
            end
            load_iv(16'hC0DE + md[15:0]);
            for (int i = 0; i < 40; i++) begin
                lat = (i * 3) % 4;
                if (md == 1) run_block(md, 1'b1, ct_buf[i], "R2 counter decrypt", got);
                else if (md == 2) run_block(md, 1'b1, ct_buf[i], "R4 feedback decrypt", got);
                else run_block(md, 1'b1, ct_buf[i], "R6 chaining decrypt", got);
                check("R6 round trip plaintext", got, pt_buf[i]);
            end
        end

        // R3 counter wrap
        load_iv(16'hFFFF);
        run_block(1, 1'b0, 16'h1111, "R3 counter at all-ones", got);
        check("R3 first keystream", got, enc(16'hFFFF) ^ 16'h1111);
        run_block(1, 1'b0, 16'h2222, "R3 counter after wrap", got);
        check("R3 wrapped keystream", got, enc(16'h0000) ^ 16'h2222);

        // R11 codebook leaves the chain
        load_iv(16'h0100);
        run_block(1, 1'b0, 16'hAAAA, "R11 counter before", got);
        run_block(0, 1'b0, 16'h5555, "R11 codebook between", got);
        run_block(1, 1'b0, 16'h0F0F, "R11 counter resumes", got);
        check("R11 counter continues", got, enc(16'h0101) ^ 16'h0F0F);

        checks++;
        if (inv_bad != 0) begin
            errors++;
            $display("FAIL R2 inverse used in stream mode actual=%0d expected=0", inv_bad);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule